// File: doc/BRIEF.md
# Microcoded Accumulator Machine Controller

This block sequences a small accumulator machine from a microcode store. A microaddress register selects one of sixteen 20-bit microwords, and that word is held in a microword register for the whole microcycle. The low fourteen bits of the held word are the datapath strobes for that cycle. The upper six bits pick the following microaddress in one of three ways. Normally the microword's own next-address field supplies it, and this is how straight-line sequencing and jumps are both written. A single status bit can be OR-ed into that field to make a two-way branch. An opcode dispatch table can also replace the field.

The microcode fetches an instruction in three microcycles and then dispatches on its opcode. Two routines are provided: load-accumulator, and jump-if-accumulator-zero. A behavioural datapath with a read-only memory is included; a parameter image sets its contents. This lets the complete machine run a program from reset. All register contents and the current microword are brought out as plain status pins, so a bench can follow every microcycle. The block has no streaming interface, so no valid/ready handshake applies.

Top module: `ucode_acc_cpu`

## Requirements
- R1: While reset is low and on the first cycle after its release, the microaddress is 0 and PC, IR, MAR, MDR and ACC are all zero.
- R2: Microword layout: bits 13:0 are strobes, with bit 13 loading MAR from the bus, 12 driving PC onto the bus, 11 incrementing PC, 10 reading memory into MDR, 9 loading IR from the bus, 8 driving MDR onto the bus, 7 driving IR[3:0] onto the bus, 6 loading ACC from the bus and 5 loading PC from the bus. Bit 14 selects dispatch, bit 15 enables the OR-in and bits 19:16 hold the next address. Word 0 reads 20'h13000, word 3 reads 20'h04000 and word 7 reads 20'h88000.
- R3: Fetch uses microaddresses 0, 1 and 2, one cycle each. Address 0 copies PC into MAR. Address 1 increments PC and captures mem[MAR] in MDR. Address 2 copies MDR into IR.
- R4: Microaddress 3 dispatches on IR[7:4]. Opcode 1 goes to 4, opcode 2 goes to 7, and every other opcode goes back to 0 with no register changed.
- R5: The load routine runs at addresses 4, 5 and 6. Address 4 copies IR[3:0] into MAR. Address 5 captures mem[MAR] in MDR. Address 6 copies MDR into ACC and returns to 0.
- R6: Address 7 ORs the ACC-is-zero bit into next address 8. With ACC nonzero it goes to 8, which changes nothing and returns to 0. With ACC zero it goes to 9, which loads PC from IR[3:0] and returns to 0.
- R7: ACC changes only in a cycle at address 6. PC changes only in cycles at address 1 or 9.
- R8: Memory word i of the 16 is MEM_IMAGE[8i+7:8i] and is read combinationally at MAR. PC is 4 bits and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csar | output | 4 | Current microaddress |
| uword | output | 20 | Microword held for this microcycle |
| pc | output | 4 | Program counter |
| ir | output | 8 | Instruction register |
| mar | output | 4 | Memory address register |
| mdr | output | 8 | Memory data register |
| acc | output | 8 | Accumulator |

## Verification
A wrong microaddress shows on the very next cycle, in two places: the csar pin and a wrong strobe pattern on uword. One cycle after that, a register moves when it should have held, or holds when it should have moved. A corrupted dispatch or OR-in branch does more than misplace one routine. Every later instruction then runs out of step, so PC and ACC drift from the program's expected trace within a few instructions. For that reason the bench compares every register and the microaddress on every cycle. It does not check only at instruction boundaries.

// File: rtl/acc_ucode_pkg.sv
`timescale 1ns/1ps
package acc_ucode_pkg;
  localparam int UADDR_W = 4;
  localparam int CTRL_W  = 14;
  localparam int UWORD_W = CTRL_W + 2 + UADDR_W;
  localparam int UDEPTH  = 1 << UADDR_W;

  // strobe bit positions inside the control field
  localparam int S_MAR_LD  = 13;
  localparam int S_PC_DRV  = 12;
  localparam int S_PC_INC  = 11;
  localparam int S_MEM_RD  = 10;
  localparam int S_IR_LD   = 9;
  localparam int S_MDR_DRV = 8;
  localparam int S_IR_DRV  = 7;
  localparam int S_ACC_LD  = 6;
  localparam int S_PC_LD   = 5;

  typedef struct packed {
    logic [UADDR_W-1:0] nxt;
    logic               or_en;
    logic               disp;
    logic [CTRL_W-1:0]  ctrl;
  } uword_t;
endpackage

// File: rtl/acc_ucode_rom.sv
`timescale 1ns/1ps
module acc_ucode_rom
  import acc_ucode_pkg::*;
(
  input  logic [UADDR_W-1:0] addr,
  output uword_t             word
);
  function automatic uword_t mk(input logic [UADDR_W-1:0] n, input logic o,
                                input logic d, input logic [CTRL_W-1:0] c);
    uword_t w;
    w.nxt = n; w.or_en = o; w.disp = d; w.ctrl = c;
    return w;
  endfunction

  function automatic logic [CTRL_W-1:0] sb(input int i);
    logic [CTRL_W-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  always_comb begin
    unique case (addr)
      4'd0: word = mk(4'd1, 1'b0, 1'b0, sb(S_MAR_LD) | sb(S_PC_DRV));
      4'd1: word = mk(4'd2, 1'b0, 1'b0, sb(S_PC_INC) | sb(S_MEM_RD));
      4'd2: word = mk(4'd3, 1'b0, 1'b0, sb(S_IR_LD)  | sb(S_MDR_DRV));
      4'd3: word = mk(4'd0, 1'b0, 1'b1, '0);
      4'd4: word = mk(4'd5, 1'b0, 1'b0, sb(S_IR_DRV) | sb(S_MAR_LD));
      4'd5: word = mk(4'd6, 1'b0, 1'b0, sb(S_MEM_RD));
      4'd6: word = mk(4'd0, 1'b0, 1'b0, sb(S_ACC_LD) | sb(S_MDR_DRV));
      4'd7: word = mk(4'd8, 1'b1, 1'b0, '0);
      4'd8: word = mk(4'd0, 1'b0, 1'b0, '0);
      4'd9: word = mk(4'd0, 1'b0, 1'b0, sb(S_IR_DRV) | sb(S_PC_LD));
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/acc_useq.sv
`timescale 1ns/1ps
module acc_useq
  import acc_ucode_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               acc_zero,
  output logic [UADDR_W-1:0] csar,
  output uword_t             csir
);
  logic [UADDR_W-1:0] nxt_addr;
  logic [UADDR_W-1:0] disp_addr;
  uword_t             rom_word;

  // opcode dispatch table
  always_comb begin
    case (opcode)
      OPC_W'(1): disp_addr = UADDR_W'(4);
      OPC_W'(2): disp_addr = UADDR_W'(7);
      default:   disp_addr = '0;
    endcase
  end

  always_comb begin
    if (csir.disp) nxt_addr = disp_addr;
    else           nxt_addr = csir.nxt | {{(UADDR_W-1){1'b0}}, csir.or_en & acc_zero};
  end

  acc_ucode_rom i_rom (.addr(rst_n ? nxt_addr : '0), .word(rom_word));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csar <= '0;
      csir <= rom_word;
    end else begin
      csar <= nxt_addr;
      csir <= rom_word;
    end
  end

  AST_DISPATCH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    csir.disp |=> (csar == 4'd0 || csar == 4'd4 || csar == 4'd7)) else $error("dispatch"); // R4
  AST_LOAD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    csir.ctrl[S_ACC_LD] |=> csar == 4'd0) else $error("load return"); // R5
  AST_OR_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    csir.or_en |=> (csar == 4'd8 || csar == 4'd9)) else $error("or branch"); // R6
endmodule

// File: rtl/acc_dp.sv
`timescale 1ns/1ps
module acc_dp
  import acc_ucode_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] MEM_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] acc
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bus;

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    assign mem[i] = MEM_IMAGE[i*DATA_W +: DATA_W];
  end

  always_comb begin
    bus = '0;
    if (ctrl[S_PC_DRV])  bus = DATA_W'(pc);
    if (ctrl[S_IR_DRV])  bus = DATA_W'(ir[ADDR_W-1:0]);
    if (ctrl[S_MDR_DRV]) bus = mdr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; ir <= '0; mar <= '0; mdr <= '0; acc <= '0;
    end else begin
      if (ctrl[S_PC_INC])     pc  <= pc + 1'b1;
      else if (ctrl[S_PC_LD]) pc  <= bus[ADDR_W-1:0];
      if (ctrl[S_MAR_LD])     mar <= bus[ADDR_W-1:0];
      if (ctrl[S_MEM_RD])     mdr <= mem[mar];
      if (ctrl[S_IR_LD])      ir  <= bus;
      if (ctrl[S_ACC_LD])     acc <= bus;
    end
  end

  AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl[S_PC_DRV], ctrl[S_IR_DRV], ctrl[S_MDR_DRV]})) else $error("bus"); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[S_PC_INC] |=> pc == ADDR_W'($past(pc) + 1'b1)) else $error("pc step"); // R8
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[S_ACC_LD] |=> $stable(acc)) else $error("acc hold"); // R7
  AST_IR_FROM_MDR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[S_IR_LD] |=> ir == $past(mdr)) else $error("ir load"); // R3
endmodule

// File: rtl/ucode_acc_cpu.sv
`timescale 1ns/1ps
module ucode_acc_cpu
  import acc_ucode_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] MEM_IMAGE = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [UADDR_W-1:0]  csar,
  output logic [UWORD_W-1:0]  uword,
  output logic [ADDR_W-1:0]   pc,
  output logic [DATA_W-1:0]   ir,
  output logic [ADDR_W-1:0]   mar,
  output logic [DATA_W-1:0]   mdr,
  output logic [DATA_W-1:0]   acc
);
  localparam int OPC_W = DATA_W - ADDR_W;

  uword_t csir;

  acc_useq #(.OPC_W(OPC_W)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .opcode(ir[DATA_W-1:ADDR_W]), .acc_zero(acc == '0),
    .csar(csar), .csir(csir)
  );

  acc_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_IMAGE(MEM_IMAGE)) i_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(csir.ctrl),
    .pc(pc), .ir(ir), .mar(mar), .mdr(mdr), .acc(acc)
  );

  assign uword = csir;
endmodule

// File: tb/test_ucode_acc_cpu.sv
`timescale 1ns/1ps
module test_ucode_acc_cpu;
  localparam logic [127:0] IMG = {
    8'h00, 8'h81, 8'h00, 8'h00, 8'h5F, 8'h00, 8'h1E, 8'hF3,
    8'h00, 8'h20, 8'h1B, 8'h00, 8'h00, 8'h00, 8'h25, 8'h1A };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] csar, pc, mar;
  logic [19:0] uword;
  logic [7:0] ir, mdr, acc;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ucode_acc_cpu #(.MEM_IMAGE(IMG)) i_ucode_acc_cpu (
    .clk(clk), .rst_n(rst_n), .csar(csar), .uword(uword),
    .pc(pc), .ir(ir), .mar(mar), .mdr(mdr), .acc(acc));

  // reference model state
  int m_pc, m_ir, m_mar, m_mdr, m_acc, m_upc;

  function automatic int memrd(input int a);
    return int'(IMG[a*8 +: 8]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " csar"}, int'(csar), m_upc);
    chk({tag, " pc"},   int'(pc),   m_pc);
    chk({tag, " ir"},   int'(ir),   m_ir);
    chk({tag, " mar"},  int'(mar),  m_mar);
    chk({tag, " mdr"},  int'(mdr),  m_mdr);
    chk({tag, " acc R7"}, int'(acc), m_acc);
  endtask

  // one microcycle of the instruction-level model; returns requirement tag
  function automatic string step();
    string t;
    case (m_upc)
      0: begin m_mar = m_pc; m_upc = 1; t = "R3"; end
      1: begin m_mdr = memrd(m_mar); m_pc = (m_pc + 1) % 16; m_upc = 2; t = "R8"; end
      2: begin m_ir = m_mdr; m_upc = 3; t = "R3"; end
      3: begin
           m_upc = ((m_ir >> 4) == 1) ? 4 : ((m_ir >> 4) == 2) ? 7 : 0;
           t = "R4";
         end
      4: begin m_mar = m_ir % 16; m_upc = 5; t = "R5"; end
      5: begin m_mdr = memrd(m_mar); m_upc = 6; t = "R5"; end
      6: begin m_acc = m_mdr; m_upc = 0; t = "R5"; end
      7: begin m_upc = (m_acc == 0) ? 9 : 8; t = "R6"; end
      8: begin m_upc = 0; t = "R6"; end
      9: begin m_pc = m_ir % 16; m_upc = 0; t = "R6"; end
      default: begin m_upc = 0; t = "R4"; end
    endcase
    return t;
  endfunction

  initial begin
    m_pc = 0; m_ir = 0; m_mar = 0; m_mdr = 0; m_acc = 0; m_upc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp_all("R1 in reset");
    chk("R2 word0", int'(uword), 'h13000);
    rst_n = 1'b1;
    cmp_all("R1 after release");
    for (int c = 0; c < 120; c++) begin
      string tg;
      @(posedge clk);
      @(negedge clk);
      tg = step();
      cmp_all(tg);
      if (m_upc == 3) chk("R2 dispatch word", int'(uword), 'h04000);
      if (m_upc == 7) chk("R2 or word", int'(uword), 'h88000);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule